// File: doc/BRIEF.md
# Dual-Rail Early-Output AND Stage

This block is one stage of a delay-insensitive pipeline. It forms the logical AND of several dual-rail encoded bits and exchanges data with its neighbours through four-phase return-to-zero handshakes. Each operand arrives on its own two-wire channel and has its own acknowledge back to its sender. The result leaves on one two-wire channel and has one acknowledge back from the receiver. The logic is modelled as clocked registers, so that it fits a synchronous code base. All ordering comes from the handshakes, and no delay bound is assumed.

The stage produces its result as soon as the operands present are enough to decide it. A single operand at logic zero settles the output to zero, even while the other operands are still spacers. Each operand channel has its own completion tracker. A late operand is absorbed and acknowledged after the result has gone out, and the output is held until that happens. The late operand therefore cannot leak into the next token.

The controller has four states. In IDLE the output is a spacer and the controller waits for a decision. HOLD drives the result and waits for the receiver to acknowledge it. In DRAIN the receiver has acknowledged, and the stage acknowledges and drains each operand. In RTZ the output is a spacer again and the controller waits for every acknowledge to be released. The transitions are as follows:
- decide (IDLE to HOLD): the result is known.
- accept (HOLD to DRAIN): the receiver acknowledge is seen high.
- release (DRAIN to RTZ): every operand has been acknowledged and is back at spacer.
- rearm (RTZ to IDLE): every operand acknowledge is low.

Top module: `eo_and_stage`

## Requirements
- R1: Every channel uses a two-bit code: 00 is the spacer, 01 is logic zero and 10 is logic one. Operand i occupies bits [2i+1:2i] of `in_rail`. The output never carries 11.
- R2: In IDLE, if any operand is logic zero, the output shows logic zero one clock later, even when the other operands are still spacers.
- R3: The output shows logic one only when every operand is logic one. It appears one clock after the last operand arrives and stays a spacer while any operand is missing.
- R4: Once a result is driven, it stays unchanged while the receiver acknowledge is low.
- R5: An operand acknowledge rises only while the receiver acknowledge is high and that operand carries data. It rises one clock after both conditions hold in DRAIN.
- R6: An operand that arrives after the result has gone out is still acknowledged. The output keeps the result until every operand has been acknowledged, and each token is delivered exactly once.
- R7: The output returns to spacer one clock after every operand is a spacer and every operand acknowledge is high, and not before.
- R8: An operand acknowledge falls only when the receiver acknowledge is low and that operand is a spacer. A new result is produced only after every operand acknowledge is low.
- R9: While reset is held, the output is a spacer and every operand acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_rail | input | 2*N_IN | Dual-rail operands, two bits per operand |
| in_ack | output | N_IN | Acknowledge to each operand sender |
| out_rail | output | 2 | Dual-rail result |
| out_ack | input | 1 | Acknowledge from the receiver |

## Verification
The bench builds the stage with the default N_IN = 2. With two operands, every arrival order can be reached in directed tests: zero first with the other missing, one first with the other missing, both together, and each late side. All four value pairs can be enumerated as well. A forked stress task draws separate random delays for each sender and for the receiver. This exercises interleavings in which a late operand arrives while the stage is in DRAIN, and the bench confirms that the token count matches exactly.

// File: rtl/eo_and_pkg.sv
package eo_and_pkg;
    typedef logic [1:0] rail_t;

    localparam rail_t RAIL_NULL = 2'b00;
    localparam rail_t RAIL_ZERO = 2'b01;
    localparam rail_t RAIL_ONE  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_RTZ   = 2'd3
    } st_e;
endpackage

// File: rtl/eo_and_decide.sv
module eo_and_decide
    import eo_and_pkg::*;
#(
    parameter int N_IN = 2
) (
    input  logic [2*N_IN-1:0] rails,
    output logic              ready,
    output logic              value,
    output logic              all_null
);
    logic any_zero;
    logic all_one;

    always_comb begin
        any_zero = 1'b0;
        all_one  = 1'b1;
        all_null = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            if (rails[2*i +: 2] == RAIL_ZERO) any_zero = 1'b1;
            if (rails[2*i +: 2] != RAIL_ONE)  all_one  = 1'b0;
            if (rails[2*i +: 2] != RAIL_NULL) all_null = 1'b0;
        end
        ready = any_zero | all_one;
        value = all_one & ~any_zero;
    end
endmodule

// File: rtl/eo_and_ack.sv
module eo_and_ack
    import eo_and_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  rail_t rail,
    input  logic  draining,
    input  logic  returning,
    input  logic  out_ack,
    output logic  ack
);
    logic has_data;
    assign has_data = (rail == RAIL_ZERO) || (rail == RAIL_ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
        end else if (draining && out_ack && has_data) begin
            ack <= 1'b1;
        end else if (returning && !out_ack && rail == RAIL_NULL) begin
            ack <= 1'b0;
        end
    end
endmodule

// File: rtl/eo_and_ctrl.sv
module eo_and_ctrl
    import eo_and_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ready,
    input  logic  value,
    input  logic  all_null,
    input  logic  all_acked,
    input  logic  none_acked,
    input  logic  out_ack,
    output st_e   state,
    output rail_t out_rail
);
    st_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (ready)                  state_nx = ST_HOLD;
            ST_HOLD:  if (out_ack)                state_nx = ST_DRAIN;
            ST_DRAIN: if (all_acked && all_null)  state_nx = ST_RTZ;
            ST_RTZ:   if (none_acked)             state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_rail <= RAIL_NULL;
        end else begin
            unique case (state)
                ST_IDLE:  if (ready) out_rail <= value ? RAIL_ONE : RAIL_ZERO;
                ST_HOLD:  out_rail <= out_rail;
                ST_DRAIN: if (all_acked && all_null) out_rail <= RAIL_NULL;
                ST_RTZ:   out_rail <= RAIL_NULL;
                default:  out_rail <= RAIL_NULL;
            endcase
        end
    end
endmodule

// File: rtl/eo_and_stage.sv
module eo_and_stage
    import eo_and_pkg::*;
#(
    parameter int N_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*N_IN-1:0] in_rail,
    output logic [N_IN-1:0]   in_ack,
    output logic [1:0]        out_rail,
    input  logic              out_ack
);
    st_e  state;
    logic ready;
    logic value;
    logic all_null;
    logic draining;
    logic returning;

    assign draining  = (state == ST_DRAIN);
    assign returning = (state == ST_RTZ);

    eo_and_decide #(.N_IN(N_IN)) u_decide (
        .rails    (in_rail),
        .ready    (ready),
        .value    (value),
        .all_null (all_null)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_port
        eo_and_ack u_ack (
            .clk       (clk),
            .rst_n     (rst_n),
            .rail      (in_rail[2*g +: 2]),
            .draining  (draining),
            .returning (returning),
            .out_ack   (out_ack),
            .ack       (in_ack[g])
        );
    end

    eo_and_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .value      (value),
        .all_null   (all_null),
        .all_acked  (&in_ack),
        .none_acked (~|in_ack),
        .out_ack    (out_ack),
        .state      (state),
        .out_rail   (out_rail)
    );
endmodule

// File: rtl/eo_and_stage_chk.sv
module eo_and_stage_chk
    import eo_and_pkg::*;
#(
    parameter int N_IN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2*N_IN-1:0] in_rail,
    input logic [N_IN-1:0]   in_ack,
    input logic [1:0]        out_rail,
    input logic              out_ack,
    input st_e               state
);
    logic any_zero_c;
    logic all_one_c;
    logic all_null_c;

    always_comb begin
        any_zero_c = 1'b0;
        all_one_c  = 1'b1;
        all_null_c = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            any_zero_c = any_zero_c | (in_rail[2*i +: 2] == 2'b01);
            all_one_c  = all_one_c  & (in_rail[2*i +: 2] == 2'b10);
            all_null_c = all_null_c & (in_rail[2*i +: 2] == 2'b00);
        end
    end

    assert_out_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_rail != 2'b11);

    assert_early_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && any_zero_c) |=> out_rail == 2'b01);

    assert_one_needs_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rail == 2'b10 && $past(out_rail) != 2'b10) |-> $past(all_one_c));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rail != 2'b00 && !out_ack) |=> out_rail == $past(out_rail));

    assert_rtz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rail == 2'b00 && $past(out_rail) != 2'b00) |-> $past(all_null_c && (&in_ack)));

    assert_new_token_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rail != 2'b00 && $past(out_rail) == 2'b00) |-> $past(in_ack == '0));

    for (genvar g = 0; g < N_IN; g++) begin : g_chk
        assert_in_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
            in_rail[2*g +: 2] != 2'b11);

        assert_ack_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(in_ack[g]) |-> ($past(out_ack) && $past(in_rail[2*g +: 2]) != 2'b00));

        assert_ack_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(in_ack[g]) |-> (!$past(out_ack) && $past(in_rail[2*g +: 2]) == 2'b00));
    end
endmodule

bind eo_and_stage eo_and_stage_chk #(.N_IN(N_IN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_rail  (in_rail),
    .in_ack   (in_ack),
    .out_rail (out_rail),
    .out_ack  (out_ack),
    .state    (state)
);

// File: tb/eo_and_stage_test.sv
module eo_and_stage_test;
    localparam int N = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] in_rail = '0;
    logic [N-1:0]   in_ack;
    logic [1:0]     out_rail;
    logic           out_ack = 1'b0;

    int checks = 0;
    int fails = 0;
    int tokens_seen = 0;
    int tokens_sent = 0;
    bit illegal_seen = 1'b0;
    logic [1:0] prev_out = 2'b00;

    always #4 clk = ~clk;

    eo_and_stage #(.N_IN(N)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_rail  (in_rail),
        .in_ack   (in_ack),
        .out_rail (out_rail),
        .out_ack  (out_ack)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_rail == 2'b11) illegal_seen = 1'b1;
            if (out_rail != 2'b00 && prev_out == 2'b00) tokens_seen++;
            prev_out = out_rail;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int i, input logic [1:0] v);
        in_rail[2*i +: 2] = v;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [1:0] enc(input int b);
        return b ? 2'b10 : 2'b01;
    endfunction

    // Completes a token whose operands are all driven.
    task automatic finish_token();
        out_ack = 1'b1;
        while (out_rail != 2'b00) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) if (in_ack[i]) put(i, 2'b00);
        end
        out_ack = 1'b0;
        while (in_ack != '0) @(negedge clk);
        cyc(2);
    endtask

    task automatic t_reset();
        cyc(1);
        chk(out_rail == 2'b00, "R9 out spacer in reset", out_rail, 0);
        chk(in_ack == '0, "R9 acks low in reset", in_ack, 0);
        rst_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_early_zero_late_one();
        tokens_sent++;
        put(0, 2'b01);
        cyc(1);
        chk(out_rail == 2'b01, "R2 early zero with other spacer", out_rail, 1);
        cyc(5);
        chk(out_rail == 2'b01, "R4 result held without ack", out_rail, 1);
        chk(in_ack == '0, "R5 no ack without receiver ack", in_ack, 0);
        out_ack = 1'b1;
        cyc(2);
        chk(in_ack == 2'b01, "R5 present operand acked", in_ack, 1);
        put(0, 2'b00);
        cyc(4);
        chk(out_rail == 2'b01, "R6 result kept while late operand missing", out_rail, 1);
        chk(in_ack == 2'b01, "R6 late operand not yet acked", in_ack, 1);
        put(1, 2'b10);
        cyc(1);
        chk(in_ack == 2'b11, "R6 late operand absorbed", in_ack, 3);
        chk(out_rail == 2'b01, "R7 no spacer before operand returns", out_rail, 1);
        put(1, 2'b00);
        cyc(1);
        chk(out_rail == 2'b00, "R7 spacer after all returned", out_rail, 0);
        cyc(3);
        chk(in_ack == 2'b11, "R8 acks held while receiver ack high", in_ack, 3);
        out_ack = 1'b0;
        cyc(1);
        chk(in_ack == 2'b00, "R8 acks fall after receiver release", in_ack, 0);
        cyc(2);
    endtask

    task automatic t_one_waits();
        tokens_sent++;
        put(0, 2'b10);
        cyc(6);
        chk(out_rail == 2'b00, "R3 no one while operand missing", out_rail, 0);
        put(1, 2'b10);
        cyc(1);
        chk(out_rail == 2'b10, "R3 one after all ones", out_rail, 2);
        finish_token();
    endtask

    task automatic t_zero_second_port();
        tokens_sent++;
        put(1, 2'b01);
        cyc(1);
        chk(out_rail == 2'b01, "R2 early zero on second operand", out_rail, 1);
        put(0, 2'b10);
        finish_token();
        chk(out_rail == 2'b00, "R8 stage idle after token", out_rail, 0);
    endtask

    task automatic t_all_pairs();
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                tokens_sent++;
                put(0, enc(a));
                put(1, enc(b));
                cyc(1);
                chk(out_rail == enc(a & b), "R1 code of AND result", out_rail, enc(a & b));
                finish_token();
            end
        end
    endtask

    task automatic t_stress();
        int bad = 0;
        for (int t = 0; t < 40; t++) begin
            int va = $urandom_range(0, 1);
            int vb = $urandom_range(0, 1);
            int da = $urandom_range(0, 12);
            int db = $urandom_range(0, 12);
            int dr = $urandom_range(0, 6);
            logic [1:0] got = 2'b00;
            tokens_sent++;
            fork
                begin
                    cyc(da);
                    put(0, enc(va));
                    while (!in_ack[0]) @(negedge clk);
                    put(0, 2'b00);
                    while (in_ack[0]) @(negedge clk);
                end
                begin
                    cyc(db);
                    put(1, enc(vb));
                    while (!in_ack[1]) @(negedge clk);
                    put(1, 2'b00);
                    while (in_ack[1]) @(negedge clk);
                end
                begin
                    @(negedge clk);
                    while (out_rail == 2'b00) @(negedge clk);
                    got = out_rail;
                    cyc(dr);
                    out_ack = 1'b1;
                    while (out_rail != 2'b00) @(negedge clk);
                    cyc(dr);
                    out_ack = 1'b0;
                end
            join
            cyc(2);
            if (got != enc(va & vb)) begin
                bad++;
                chk(1'b0, "R6 stress token value", got, enc(va & vb));
            end
        end
        chk(bad == 0, "R6 stress tokens correct", bad, 0);
        chk(tokens_seen == tokens_sent, "R6 each token delivered once", tokens_seen, tokens_sent);
        chk(!illegal_seen, "R1 output never 11", illegal_seen, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_early_zero_late_one();
        t_one_waits();
        t_zero_second_port();
        t_all_pairs();
        t_stress();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule